// File: doc/BRIEF.md
# Streaming Fixed-Permutation Engine

This block reorders a continuous stream of vectors of N elements. Each vector, called a frame, arrives as N/P consecutive beats of P elements. It leaves in permuted order at the same rate of P elements per clock. Inside a frame the stream never stalls.

Each element first crosses an input network of 2x2 switches, which steers it to one of P memory banks. It is written there, and one frame later it is read back. An output network of 2x2 switches then steers it to its output lane. For every beat of a frame, a set of control tables supplies the setting of every switch and the address used in every bank. A host fills these tables through a small write port while the engine is idle. Which permutation the engine applies depends only on the table contents. The routing that produces those contents is computed elsewhere.

Each bank holds two halves. One frame is written into one half while the previous frame drains from the other half, so frames may follow each other with no gap.

Top module: `perm_stream_engine`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_data` are 0 after that edge.
- R2: Lane k of a beat occupies bits [k*W +: W] of `in_data` and `out_data`. Beat c of a frame (c counted from 0) carries elements c*P .. c*P+P-1 of the vector, with lane k holding element c*P+k.
- R3: The input network has log2(P) layers of P/2 switches. Switch s of layer l joins the two positions that differ only in bit l: the lower position is s with a 0 inserted at bit l. The switch is controlled by bit l*(P/2)+s of the configuration word, where 0 passes straight and 1 crosses. Output position b of the network feeds bank b.
- R4: The output network has the same structure and bit encoding. It takes bank b's read data at position b and produces output lane positions.
- R5: On beat c of an incoming frame, bank b writes its element at address wtab[c][b] in the half owned by that frame. On read step c of a completed frame, bank b reads address rtab[c][b] from that frame's half. The input network uses the word itab[c] and the output network uses the word otab[c].
- R6: The first output beat of a frame is presented after the clock edge that comes N/P edges after the edge that accepted the frame's first input beat. The N/P output beats follow on consecutive cycles. `out_data` is 0 whenever `out_valid` is low.
- R7: A new frame may begin on the cycle after the previous frame's last beat. Its data goes to the other bank half, and the output stays continuous across the frame boundary with correct data.
- R8: `in_valid` may be low between frames. The beat position advances only on accepted beats.
- R9: A configuration write (`cfg_we`=1) stores `cfg_data` into a table selected by `cfg_sel`, at frame step `cfg_cycle`: 0 selects the input word, 1 the write address of bank `cfg_lane`, 2 the read address of bank `cfg_lane`, and 3 the output word. The new value is used by frames that start after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table select (0 input word, 1 write address, 2 read address, 3 output word) |
| cfg_cycle | input | log2(N/P) | Frame step of the entry |
| cfg_lane | input | log2(P) | Bank of an address entry |
| cfg_data | input | max(log2(P)*P/2, log2(N/P)) | Entry value |
| in_valid | input | 1 | Input beat present |
| in_data | input | P*W | Input beat, P lanes |
| out_valid | output | 1 | Output beat present |
| out_data | output | P*W | Output beat, P lanes |

## Verification
Two activities can fall in the same cycle: writing the last beat of frame f+1 into one bank half, and reading the final step of frame f from the other half. On that same edge the read sequencer also restarts for the new frame. The bench provokes this overlap by sending frames back to back under several table sets, including a stride transpose whose bank addresses differ per bank. A behavioural model schedules every expected beat by clock number. The bench then compares `out_valid` and `out_data` on every cycle, so a lost beat, a gap at the boundary or mixed halves shows up as a miscompare.

// File: rtl/perm_pkg.sv
package perm_pkg;
   // lower position of switch s in butterfly layer l: s with a 0 inserted at bit l
   function automatic int pair_lo(input int l, input int s);
      return ((s >> l) << (l + 1)) | (s & ((1 << l) - 1));
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/perm_butterfly.sv
module perm_butterfly #(
   parameter int P = 4,
   parameter int W = 8,
   localparam int LOGP = $clog2(P),
   localparam int HALF = P / 2,
   localparam int SWB  = LOGP * HALF
) (
   input  logic [P*W-1:0] din,
   input  logic [SWB-1:0] cfg,
   output logic [P*W-1:0] dout
);
   logic [LOGP:0][P-1:0][W-1:0] st;

   assign st[0] = din;

   for (genvar l = 0; l < LOGP; l++) begin : g_layer
      for (genvar s = 0; s < HALF; s++) begin : g_sw
         localparam int LO = perm_pkg::pair_lo(l, s);
         localparam int HI = LO + (1 << l);
         assign st[l+1][LO] = cfg[l*HALF+s] ? st[l][HI] : st[l][LO];
         assign st[l+1][HI] = cfg[l*HALF+s] ? st[l][LO] : st[l][HI];
      end
   end

   assign dout = st[LOGP];
endmodule

// File: rtl/perm_ctrl_tab.sv
module perm_ctrl_tab #(
   parameter int P     = 4,
   parameter int DEPTH = 4,
   parameter int AW    = 2,
   parameter int LW    = 2,
   parameter int SWB   = 4,
   parameter int CW    = 4
) (
   input  logic            clk,
   input  logic            cfg_we,
   input  logic [1:0]      cfg_sel,
   input  logic [AW-1:0]   cfg_cycle,
   input  logic [LW-1:0]   cfg_lane,
   input  logic [CW-1:0]   cfg_data,
   input  logic [AW-1:0]   wstep,
   input  logic [AW-1:0]   rstep,
   output logic [SWB-1:0]  in_word,
   output logic [P*AW-1:0] wr_addr,
   output logic [P*AW-1:0] rd_addr,
   output logic [SWB-1:0]  out_word
);
   logic [SWB-1:0]          in_tab  [DEPTH];
   logic [SWB-1:0]          out_tab [DEPTH];
   logic [P-1:0][AW-1:0]    wa_tab  [DEPTH];
   logic [P-1:0][AW-1:0]    ra_tab  [DEPTH];

   always_ff @(posedge clk) begin
      if (cfg_we) begin
         case (cfg_sel)
            2'd0:    in_tab[cfg_cycle]            <= cfg_data[SWB-1:0];
            2'd1:    wa_tab[cfg_cycle][cfg_lane]  <= cfg_data[AW-1:0];
            2'd2:    ra_tab[cfg_cycle][cfg_lane]  <= cfg_data[AW-1:0];
            default: out_tab[cfg_cycle]           <= cfg_data[SWB-1:0];
         endcase
      end
   end

   assign in_word  = in_tab[wstep];
   assign wr_addr  = wa_tab[wstep];
   assign rd_addr  = ra_tab[rstep];
   assign out_word = out_tab[rstep];
endmodule

// File: rtl/perm_bank.sv
module perm_bank #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   parameter int AW    = 2
) (
   input  logic          clk,
   input  logic          we,
   input  logic          wpar,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          rpar,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [2*DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[{wpar, waddr}] <= wdata;
   end

   assign rdata = mem[{rpar, raddr}];
endmodule

// File: rtl/perm_stream_engine.sv
module perm_stream_engine #(
   parameter int N = 16,
   parameter int P = 4,
   parameter int W = 8,
   localparam int DEPTH = N / P,
   localparam int AW    = $clog2(DEPTH),
   localparam int LW    = $clog2(P),
   localparam int SWB   = $clog2(P) * (P / 2),
   localparam int CW    = perm_pkg::max_int(SWB, AW)
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           cfg_we,
   input  logic [1:0]     cfg_sel,
   input  logic [AW-1:0]  cfg_cycle,
   input  logic [LW-1:0]  cfg_lane,
   input  logic [CW-1:0]  cfg_data,
   input  logic           in_valid,
   input  logic [P*W-1:0] in_data,
   output logic           out_valid,
   output logic [P*W-1:0] out_data
);
   if (P < 2 || (P & (P - 1)) != 0) begin : g_bad_p
      $error("perm_stream_engine: P must be a power of two, at least 2");
   end
   if ((N & (N - 1)) != 0 || N <= P) begin : g_bad_n
      $error("perm_stream_engine: N must be a power of two above P");
   end
   if (W < 1) begin : g_bad_w
      $error("perm_stream_engine: W must be positive");
   end

   logic [AW-1:0]   wstep, rstep;
   logic            wpar, rpar, rd_on;
   logic            w_last, r_last;
   logic [SWB-1:0]  in_word, out_word;
   logic [P*AW-1:0] wr_addr, rd_addr;
   logic [P*W-1:0]  bank_in, bank_out, net_out;

   assign w_last = (wstep == AW'(DEPTH - 1));
   assign r_last = (rstep == AW'(DEPTH - 1));

   perm_ctrl_tab #(.P(P), .DEPTH(DEPTH), .AW(AW), .LW(LW), .SWB(SWB), .CW(CW)) u_tab (
      .clk      (clk),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_cycle(cfg_cycle),
      .cfg_lane (cfg_lane),
      .cfg_data (cfg_data),
      .wstep    (wstep),
      .rstep    (rstep),
      .in_word  (in_word),
      .wr_addr  (wr_addr),
      .rd_addr  (rd_addr),
      .out_word (out_word)
   );

   perm_butterfly #(.P(P), .W(W)) u_in_net (
      .din (in_data),
      .cfg (in_word),
      .dout(bank_in)
   );

   for (genvar b = 0; b < P; b++) begin : g_bank
      perm_bank #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_bank (
         .clk  (clk),
         .we   (in_valid),
         .wpar (wpar),
         .waddr(wr_addr[b*AW +: AW]),
         .wdata(bank_in[b*W +: W]),
         .rpar (rpar),
         .raddr(rd_addr[b*AW +: AW]),
         .rdata(bank_out[b*W +: W])
      );
   end

   perm_butterfly #(.P(P), .W(W)) u_out_net (
      .din (bank_out),
      .cfg (out_word),
      .dout(net_out)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         wstep     <= '0;
         wpar      <= 1'b0;
         rstep     <= '0;
         rpar      <= 1'b0;
         rd_on     <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         if (in_valid) begin
            wstep <= w_last ? '0 : wstep + 1'b1;
            if (w_last) wpar <= ~wpar;
         end
         if (in_valid && w_last) begin
            rd_on <= 1'b1;
            rstep <= '0;
            rpar  <= wpar;
         end else if (rd_on) begin
            if (r_last) rd_on <= 1'b0;
            rstep <= r_last ? '0 : rstep + 1'b1;
         end
         out_valid <= rd_on;
         out_data  <= rd_on ? net_out : '0;
      end
   end
endmodule

// File: rtl/perm_stream_chk.sv
module perm_stream_chk #(
   parameter int N = 16,
   parameter int P = 4
) (
   input logic clk,
   input logic rst,
   input logic in_valid,
   input logic out_valid
);
   localparam int DEPTH = N / P;

   int icnt, vrun, ibeats, obeats;

   always_ff @(posedge clk) begin
      if (rst) begin
         icnt   <= 0;
         vrun   <= 0;
         ibeats <= 0;
         obeats <= 0;
      end else begin
         if (in_valid) icnt <= (icnt == DEPTH - 1) ? 0 : icnt + 1;
         ibeats <= ibeats + (in_valid ? 1 : 0);
         obeats <= obeats + (out_valid ? 1 : 0);
         vrun   <= out_valid ? vrun + 1 : 0;
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !out_valid); // R1

   AST_FRAME_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (in_valid && icnt == DEPTH - 1) |=> ##1 out_valid); // R6

   AST_NO_EARLY_BEAT: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (obeats < ibeats)); // R6

   AST_WHOLE_FRAMES: assert property (@(posedge clk) disable iff (rst)
      $fell(out_valid) |-> ((vrun % DEPTH) == 0)); // R7
endmodule

bind perm_stream_engine perm_stream_chk #(.N(N), .P(P)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .out_valid(out_valid)
);

// File: tb/tb_perm_stream_engine.sv
module tb_perm_stream_engine;
   localparam int N = 16, P = 4, W = 8;
   localparam int DEPTH = N / P, AW = 2, LW = 2, HALF = P / 2, LOGP = 2, CW = 4;

   logic           clk = 1'b0;
   logic           rst, cfg_we, in_valid;
   logic [1:0]     cfg_sel;
   logic [AW-1:0]  cfg_cycle;
   logic [LW-1:0]  cfg_lane;
   logic [CW-1:0]  cfg_data;
   logic [P*W-1:0] in_data, out_data;
   logic           out_valid;

   always #4 clk = ~clk;

   perm_stream_engine #(.N(N), .P(P), .W(W)) dut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_cycle(cfg_cycle),
      .cfg_lane(cfg_lane), .cfg_data(cfg_data), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   int    cyc = 0;
   int    vectors = 0, miscompares = 0;
   string tag = "R1";
   int             exp_cyc[$];
   logic [P*W-1:0] exp_dat[$];

   always @(posedge clk) cyc <= cyc + 1;

   // kinds: 0 identity, 1 stride transpose, 2 lane reversal, 3 neighbour swap
   function automatic int in_x(int kind, int c);
      return (kind == 1) ? c : (kind == 3) ? 1 : 0;
   endfunction
   function automatic int out_x(int kind, int c);
      return (kind == 1) ? c : (kind == 2) ? 3 : 0;
   endfunction
   function automatic int wa(int kind, int c, int b);
      return c + 0 * kind + 0 * b;
   endfunction
   function automatic int ra(int kind, int c, int b);
      return (kind == 1) ? (b ^ c) : c;
   endfunction
   function automatic int src_of(int kind, int i);
      int c = i / P, k = i % P;
      case (kind)
         1:       return k * P + c;
         2:       return c * P + (k ^ 3);
         3:       return c * P + (k ^ 1);
         default: return i;
      endcase
   endfunction
   function automatic logic [CW-1:0] xor_word(int x);
      logic [CW-1:0] w = '0;
      for (int l = 0; l < LOGP; l++)
         for (int s = 0; s < HALF; s++)
            if (((x >> l) & 1) == 1) w[l*HALF+s] = 1'b1;
      return w;
   endfunction

   task automatic tick();
      logic           ev;
      logic [P*W-1:0] ed;
      @(negedge clk);
      vectors++;
      ev = (exp_cyc.size() > 0) && (exp_cyc[0] == cyc);
      ed = '0;
      if (ev) begin
         ed = exp_dat[0];
         void'(exp_cyc.pop_front());
         void'(exp_dat.pop_front());
      end
      if (out_valid !== ev || out_data !== ed) begin
         miscompares++;
         $display("FAIL %s cycle %0d: out_valid=%b out_data=%h, expected out_valid=%b out_data=%h",
                  tag, cyc, out_valid, out_data, ev, ed);
      end
   endtask

   task automatic cfg_write(int sel, int c, int lane, logic [CW-1:0] d);
      cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_cycle = AW'(c); cfg_lane = LW'(lane); cfg_data = d;
      tick();
      cfg_we = 1'b0;
   endtask

   // R9: table select 0 input word, 1 write address, 2 read address, 3 output word
   task automatic load(int kind);
      for (int c = 0; c < DEPTH; c++) begin
         cfg_write(0, c, 0, xor_word(in_x(kind, c)));
         cfg_write(3, c, 0, xor_word(out_x(kind, c)));
         for (int b = 0; b < P; b++) begin
            cfg_write(1, c, b, CW'(wa(kind, c, b)));
            cfg_write(2, c, b, CW'(ra(kind, c, b)));
         end
      end
   endtask

   task automatic send_frame(int kind);
      logic [W-1:0]   x [N];
      logic [P*W-1:0] beat;
      int             base;
      for (int i = 0; i < N; i++) x[i] = W'($urandom);
      base = cyc + DEPTH + 1;  // R6: first output DEPTH edges after first accept
      for (int c = 0; c < DEPTH; c++) begin
         for (int k = 0; k < P; k++) beat[k*W +: W] = x[src_of(kind, c*P + k)];
         exp_cyc.push_back(base + c);
         exp_dat.push_back(beat);
      end
      for (int c = 0; c < DEPTH; c++) begin
         for (int k = 0; k < P; k++) beat[k*W +: W] = x[c*P + k];  // R2 lane packing
         in_valid = 1'b1;
         in_data  = beat;
         tick();
      end
      in_valid = 1'b0;
      in_data  = '0;
   endtask

   task automatic idle(int n);
      in_valid = 1'b0;
      repeat (n) tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_cycle = '0; cfg_lane = '0;
      cfg_data = '0; in_valid = 1'b0; in_data = '0;
      tag = "R1";
      tick(); tick(); tick();
      rst = 1'b0;

      tag = "R9"; load(0);
      tag = "R2 R7";                    // identity, back to back
      send_frame(0); send_frame(0);
      idle(DEPTH + 3);

      tag = "R9"; load(3);
      tag = "R3 R8";                    // input network swap, gap between frames
      send_frame(3); idle(3); send_frame(3); idle(1); send_frame(3);
      idle(DEPTH + 3);

      tag = "R9"; load(2);
      tag = "R4 R7";                    // output network reversal
      send_frame(2); send_frame(2);
      idle(DEPTH + 3);

      tag = "R5 R9"; load(1);
      tag = "R5 R7";                    // stride transpose, per-bank addresses
      send_frame(1); send_frame(1); send_frame(1); idle(2); send_frame(1);
      idle(DEPTH + 3);

      tag = "R6";
      if (exp_cyc.size() != 0) begin
         miscompares++;
         $display("FAIL R6: %0d expected beats never appeared, expected 0", exp_cyc.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule